// File: doc/BRIEF.md
# Asynchronous Page-Read Address Capture

This block sits on the device side of a word-wide NOR-style read port running in its asynchronous/page read configuration. All of its inputs are sampled in a system clock domain: an active-low chip enable, an active-low address-valid strobe and a 23-bit word address. From these it derives the effective array address. It also issues a one-cycle pulse that tells the array model to begin a full random access, or a different one-cycle pulse when the read stays inside the current 16-word page and can be served at the faster in-page time.

A small read-configuration register holds two fields. The read-mode field selects asynchronous/page operation or burst operation, and the block only starts accesses in the asynchronous/page setting. The capture field selects normal capture, where the address pins flow straight through, or latched capture. In latched capture, the upper address bits follow the pins while the strobe is low and are held once it rises. Address bits 3:0 always stay live, so the host can step through a page while the upper bits are frozen. A host that holds the strobe low permanently sees the pins tracked directly in either capture setting.

Each new access is signalled on whichever event came last: chip enable falling, the strobe falling, or a change of the effective address. Raising chip enable drops the page context, and so does the burst setting.

Top module: `page_read_addr_latch`

## Requirements
- R1: While `rst` is high and in the cycle after it, `acc_start_o`, `page_hit_o`, `burst_mode_o` and `eff_addr_o` are all 0. The configuration resets to asynchronous/page mode with normal capture.
- R2: A falling edge of `ce_n` starts a random access. `acc_start_o` is high for exactly one cycle, two clock edges after the edge was presented at the input.
- R3: A falling edge of `adv_n` while `ce_n` is low starts a random access, even if the address has not changed. A rising edge of `adv_n` in normal capture starts nothing.
- R4: While `ce_n` is low, a change of any of the effective address bits 22:4 starts a random access. Changes on consecutive cycles give consecutive pulses.
- R5: While `ce_n` stays low after a random access, a change confined to effective bits 3:0 gives a one-cycle `page_hit_o` pulse and no `acc_start_o`.
- R6: While `ce_n` is high, address and strobe activity produce no pulse, but `eff_addr_o` keeps tracking the pins. The next low-going `ce_n` starts a random access.
- R7: With latched capture selected (`cfg_latch_i`=1), bits 22:4 of `eff_addr_o` hold the value present while `adv_n` was last low. Changes on those pins while `adv_n` is high have no effect, and bits 3:0 stay live and give page hits.
- R8: With `adv_n` held low, `eff_addr_o` follows all address pins in either capture setting, and upper-bit changes start random accesses.
- R9: With burst mode selected (`cfg_burst_i`=1), no pulse of either kind is produced and the page context is dropped. On return to asynchronous/page mode, the first address change is a random access. `burst_mode_o` shows the stored mode.
- R10: `eff_addr_o` is registered and shows the effective address two clock edges after the address is presented at the input.
- R11: `acc_start_o` and `page_hit_o` are never high in the same cycle.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst | input | 1 | Synchronous reset, active high |
| cfg_we | input | 1 | Write strobe for the read-configuration fields |
| cfg_burst_i | input | 1 | Read-mode field: 0 asynchronous/page, 1 burst |
| cfg_latch_i | input | 1 | Capture field: 0 normal, 1 latched upper bits |
| ce_n | input | 1 | Chip enable, active low |
| adv_n | input | 1 | Address-valid strobe, active low |
| addr | input | 23 | Word address |
| eff_addr_o | output | 23 | Registered effective array address |
| acc_start_o | output | 1 | One-cycle pulse: begin random access |
| page_hit_o | output | 1 | One-cycle pulse: in-page access |
| burst_mode_o | output | 1 | Stored read-mode field |

## Verification
The bench steps through several corner cases and checks each outcome.
- A strobe falling edge with an unchanged address must still restart the access; a design that keys only on address changes would stay silent there.
- A low-nibble step inside a page must give a page pulse rather than a random pulse; a design that compares the wrong bit range would swap the two.
- In latched capture, an upper-bit change while the strobe is high must leave the address frozen and give no pulse; a design that lets the pins through would report a new random access.
- After a burst interlude, a same-page step must restart with a full random access; a design that keeps stale page context would flag it as a page hit instead.

// File: rtl/pal_pkg.sv
package pal_pkg;
  typedef enum logic {
    RD_ASYNC_PAGE = 1'b0,
    RD_BURST      = 1'b1
  } rd_mode_e;

  typedef struct packed {
    logic ce_fall;
    logic adv_fall;
    logic ce_low;
  } strobe_ev_t;
endpackage

// File: rtl/pal_sampler.sv
module pal_sampler #(
  parameter int AW = 23
) (
  input  logic                clk,
  input  logic                rst,
  input  logic                ce_n,
  input  logic                adv_n,
  input  logic [AW-1:0]       addr,
  output pal_pkg::strobe_ev_t ev,
  output logic                adv_low,
  output logic [AW-1:0]       addr_s
);
  logic ce_s, ce_d, adv_s, adv_d;

  always_ff @(posedge clk) begin
    if (rst) begin
      ce_s   <= 1'b1;
      ce_d   <= 1'b1;
      adv_s  <= 1'b1;
      adv_d  <= 1'b1;
      addr_s <= '0;
    end else begin
      ce_s   <= ce_n;
      ce_d   <= ce_s;
      adv_s  <= adv_n;
      adv_d  <= adv_s;
      addr_s <= addr;
    end
  end

  always_comb begin
    ev.ce_fall  = ce_d & ~ce_s;
    ev.adv_fall = adv_d & ~adv_s;
    ev.ce_low   = ~ce_s;
    adv_low     = ~adv_s;
  end
endmodule

// File: rtl/pal_upper_latch.sv
module pal_upper_latch #(
  parameter int AW = 23,
  parameter int PW = 4
) (
  input  logic          clk,
  input  logic          rst,
  input  logic          lat_en,
  input  logic          adv_low,
  input  logic [AW-1:0] addr_s,
  output logic [AW-1:0] eff
);
  localparam int UW = AW - PW;
  logic [UW-1:0] hold_q;

  always_ff @(posedge clk) begin
    if (rst)          hold_q <= '0;
    else if (adv_low) hold_q <= addr_s[AW-1:PW];
  end

  always_comb begin
    eff[PW-1:0]  = addr_s[PW-1:0];
    eff[AW-1:PW] = (lat_en && !adv_low) ? hold_q : addr_s[AW-1:PW];
  end

  AST_LATCH_FROZEN: assert property (@(posedge clk) disable iff (rst)
    (lat_en && !adv_low) |=> $stable(hold_q)); // R7
endmodule

// File: rtl/pal_access_ctl.sv
module pal_access_ctl #(
  parameter int AW = 23,
  parameter int PW = 4
) (
  input  logic                clk,
  input  logic                rst,
  input  logic                async_en,
  input  pal_pkg::strobe_ev_t ev,
  input  logic [AW-1:0]       eff,
  output logic [AW-1:0]       eff_addr_o,
  output logic                acc_start_o,
  output logic                page_hit_o
);
  localparam int UW = AW - PW;

  logic [UW-1:0] ctx_up;
  logic          ctx_vld;
  logic          eff_chg, same_page, trig, is_page, is_rand;

  always_comb begin
    eff_chg   = (eff != eff_addr_o);
    same_page = ctx_vld && (eff[AW-1:PW] == ctx_up);
    trig      = async_en && ev.ce_low && (ev.ce_fall || ev.adv_fall || eff_chg);
    is_page   = trig && !ev.ce_fall && !ev.adv_fall && same_page;
    is_rand   = trig && !is_page;
  end

  always_ff @(posedge clk) begin
    if (rst) begin
      eff_addr_o  <= '0;
      acc_start_o <= 1'b0;
      page_hit_o  <= 1'b0;
      ctx_up      <= '0;
      ctx_vld     <= 1'b0;
    end else begin
      eff_addr_o  <= eff;
      acc_start_o <= is_rand;
      page_hit_o  <= is_page;
      if (!ev.ce_low || !async_en) begin
        ctx_vld <= 1'b0;
      end else if (is_rand) begin
        ctx_vld <= 1'b1;
        ctx_up  <= eff[AW-1:PW];
      end
    end
  end

  AST_PULSE_EXCL: assert property (@(posedge clk) disable iff (rst)
    !(acc_start_o && page_hit_o)); // R11
  AST_CE_HIGH_QUIET: assert property (@(posedge clk) disable iff (rst)
    !ev.ce_low |=> (!acc_start_o && !page_hit_o)); // R6
  AST_PAGE_SAME_UPPER: assert property (@(posedge clk) disable iff (rst)
    page_hit_o |-> (eff_addr_o[AW-1:PW] == $past(eff_addr_o[AW-1:PW]))); // R5
endmodule

// File: rtl/page_read_addr_latch.sv
module page_read_addr_latch #(
  parameter int AW = 23,
  parameter int PW = 4
) (
  input  logic          clk,
  input  logic          rst,
  input  logic          cfg_we,
  input  logic          cfg_burst_i,
  input  logic          cfg_latch_i,
  input  logic          ce_n,
  input  logic          adv_n,
  input  logic [AW-1:0] addr,
  output logic [AW-1:0] eff_addr_o,
  output logic          acc_start_o,
  output logic          page_hit_o,
  output logic          burst_mode_o
);
  import pal_pkg::*;

  rd_mode_e   mode_q;
  logic       latch_q;
  strobe_ev_t ev;
  logic       adv_low;
  logic [AW-1:0] addr_s, eff;

  always_ff @(posedge clk) begin
    if (rst) begin
      mode_q  <= RD_ASYNC_PAGE;
      latch_q <= 1'b0;
    end else if (cfg_we) begin
      mode_q  <= cfg_burst_i ? RD_BURST : RD_ASYNC_PAGE;
      latch_q <= cfg_latch_i;
    end
  end

  assign burst_mode_o = (mode_q == RD_BURST);

  pal_sampler #(.AW(AW)) u_sampler (
    .clk(clk), .rst(rst), .ce_n(ce_n), .adv_n(adv_n), .addr(addr),
    .ev(ev), .adv_low(adv_low), .addr_s(addr_s)
  );

  pal_upper_latch #(.AW(AW), .PW(PW)) u_latch (
    .clk(clk), .rst(rst), .lat_en(latch_q), .adv_low(adv_low),
    .addr_s(addr_s), .eff(eff)
  );

  pal_access_ctl #(.AW(AW), .PW(PW)) u_ctl (
    .clk(clk), .rst(rst), .async_en(mode_q == RD_ASYNC_PAGE), .ev(ev),
    .eff(eff), .eff_addr_o(eff_addr_o), .acc_start_o(acc_start_o),
    .page_hit_o(page_hit_o)
  );

  AST_BURST_QUIET: assert property (@(posedge clk) disable iff (rst)
    (mode_q == RD_BURST) |=> (!acc_start_o && !page_hit_o)); // R9
endmodule

// File: tb/page_read_addr_latch_bench.sv
module page_read_addr_latch_bench;
  localparam int AW = 23;

  logic clk = 1'b0;
  logic rst = 1'b1;
  logic cfg_we = 1'b0, cfg_burst_i = 1'b0, cfg_latch_i = 1'b0;
  logic ce_n = 1'b1, adv_n = 1'b1;
  logic [AW-1:0] addr = '0;
  logic [AW-1:0] eff_addr_o;
  logic acc_start_o, page_hit_o, burst_mode_o;

  int total = 0, bad = 0, cyc = 0;
  bit done = 1'b0;

  typedef struct {
    int          due;
    logic        acc;
    logic        pg;
    logic [AW-1:0] a;
    string       tag;
  } exp_t;
  exp_t q[$];

  always #10 clk = ~clk;

  page_read_addr_latch u_page_read_addr_latch (
    .clk(clk), .rst(rst), .cfg_we(cfg_we), .cfg_burst_i(cfg_burst_i),
    .cfg_latch_i(cfg_latch_i), .ce_n(ce_n), .adv_n(adv_n), .addr(addr),
    .eff_addr_o(eff_addr_o), .acc_start_o(acc_start_o),
    .page_hit_o(page_hit_o), .burst_mode_o(burst_mode_o)
  );

  // monitor: pops expectations whose due cycle has come
  always @(posedge clk) begin
    cyc++;
    #5;
    total++;
    if (acc_start_o && page_hit_o) begin
      bad++;
      $display("FAIL R11 both pulses high acc=%0b pg=%0b exp not both", acc_start_o, page_hit_o);
    end
    while (q.size() > 0 && q[0].due == cyc) begin
      exp_t e;
      e = q.pop_front();
      total++;
      if (acc_start_o !== e.acc || page_hit_o !== e.pg || eff_addr_o !== e.a) begin
        bad++;
        $display("FAIL %s acc=%0b pg=%0b addr=%h exp acc=%0b pg=%0b addr=%h",
                 e.tag, acc_start_o, page_hit_o, eff_addr_o, e.acc, e.pg, e.a);
      end
    end
  end

  task automatic drv(input logic c, input logic v, input logic [AW-1:0] a,
                     input logic eacc, input logic epg, input logic [AW-1:0] ea,
                     input string tag);
    exp_t e;
    @(negedge clk);
    ce_n = c; adv_n = v; addr = a;
    e.due = cyc + 2; e.acc = eacc; e.pg = epg; e.a = ea; e.tag = tag;
    q.push_back(e);
  endtask

  task automatic cfg(input logic b, input logic l);
    @(negedge clk);
    cfg_we = 1'b1; cfg_burst_i = b; cfg_latch_i = l;
    @(negedge clk);
    cfg_we = 1'b0;
  endtask

  task automatic direct(input logic act, input logic expv, input string tag);
    total++;
    if (act !== expv) begin
      bad++;
      $display("FAIL %s got=%0b exp=%0b", tag, act, expv);
    end
  endtask

  initial begin
    repeat (3) @(negedge clk);
    direct(acc_start_o, 1'b0, "R1 acc in reset");
    direct(page_hit_o, 1'b0, "R1 page in reset");
    direct(burst_mode_o, 1'b0, "R1 mode in reset");
    direct(eff_addr_o == '0, 1'b1, "R1 addr in reset");
    rst = 1'b0;
    @(negedge clk);
    direct(acc_start_o | page_hit_o, 1'b0, "R1 after reset");

    drv(1, 1, 23'h012340, 0, 0, 23'h012340, "R10 tracking with ce high");
    drv(0, 1, 23'h012340, 1, 0, 23'h012340, "R2 ce fall");
    drv(0, 1, 23'h012340, 0, 0, 23'h012340, "R2 single cycle");
    drv(0, 1, 23'h012345, 0, 1, 23'h012345, "R5 in-page step");
    drv(0, 1, 23'h012345, 0, 0, 23'h012345, "R5 single cycle");
    drv(0, 1, 23'h01234A, 0, 1, 23'h01234A, "R5 second in-page step");
    drv(0, 1, 23'h012355, 1, 0, 23'h012355, "R4 upper change");
    drv(0, 1, 23'h012355, 0, 0, 23'h012355, "R4 quiet");
    drv(0, 0, 23'h012355, 1, 0, 23'h012355, "R3 adv fall same addr");
    drv(0, 1, 23'h012355, 0, 0, 23'h012355, "R3 adv rise no access");
    drv(1, 1, 23'h012355, 0, 0, 23'h012355, "R6 ce rise");
    drv(1, 0, 23'h012354, 0, 0, 23'h012354, "R6 activity while ce high");
    drv(1, 1, 23'h400000, 0, 0, 23'h400000, "R6 upper change while ce high");
    drv(0, 1, 23'h400000, 1, 0, 23'h400000, "R6 ce low again random");
    drv(0, 1, 23'h7FFFF0, 1, 0, 23'h7FFFF0, "R4 back to back a");
    drv(0, 1, 23'h000000, 1, 0, 23'h000000, "R4 back to back b");

    drv(1, 1, 23'h000000, 0, 0, 23'h000000, "R6 deselect");
    cfg(1'b0, 1'b1);
    drv(0, 0, 23'h2ABCD0, 1, 0, 23'h2ABCD0, "R7 latched capture start");
    drv(0, 1, 23'h2ABCD0, 0, 0, 23'h2ABCD0, "R7 strobe rise");
    drv(0, 1, 23'h155550, 0, 0, 23'h2ABCD0, "R7 upper frozen");
    drv(0, 1, 23'h155559, 0, 1, 23'h2ABCD9, "R7 low nibble live");
    drv(0, 0, 23'h333330, 1, 0, 23'h333330, "R8 strobe low tracks");
    drv(0, 0, 23'h444440, 1, 0, 23'h444440, "R8 upper change strobe low");

    cfg(1'b1, 1'b0);
    direct(burst_mode_o, 1'b1, "R9 mode shown");
    drv(0, 0, 23'h444441, 0, 0, 23'h444441, "R9 burst no page");
    drv(0, 0, 23'h555550, 0, 0, 23'h555550, "R9 burst no random");
    drv(0, 0, 23'h555550, 0, 0, 23'h555550, "R9 burst hold");
    cfg(1'b0, 1'b0);
    direct(burst_mode_o, 1'b0, "R9 mode back");
    drv(0, 0, 23'h555552, 1, 0, 23'h555552, "R9 context dropped");

    repeat (4) @(negedge clk);
    total++;
    if (q.size() != 0) begin
      bad++;
      $display("FAIL R10 pending=%0d exp=0", q.size());
    end
    done = 1'b1;
    $display("test done: total=%0d bad=%0d", total, bad);
    $finish;
  end

  initial begin
    repeat (5000) @(posedge clk);
    if (!done) begin
      total++;
      bad++;
      $display("FAIL watchdog got=hang exp=finish");
      $display("test done: total=%0d bad=%0d", total, bad);
      $finish;
    end
  end
endmodule